// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer and Status Unit

This block is the control side of a byte-wide NOR flash. It has a small behavioural storage array and a synchronous bus port. A write cycle (chip enable and write enable high at a clock edge) delivers either a command opcode or the operand of a command that was armed earlier. The block decodes two-write program and erase sequences and runs them over a fixed number of busy cycles. It reports readiness and failures through an 8-bit status byte. A read cycle returns either array data or that status byte, depending on the current read mode. Analog supply levels are reduced to two digital qualifiers: `vpp_good` (programming supply present) and `boot_unlock` (the high-voltage override that opens the boot block). Erase suspend is not modelled, so its status bit always reads 0.

The sequencer is a five-state machine:

- `ST_IDLE` is the ready state. It decodes opcodes:
  - FFH selects array reads.
  - 70H selects status reads.
  - 50H clears the error flags.
  - 40H moves to `ST_PROG_ARM`.
  - 20H moves to `ST_ERASE_ARM`.
- `ST_PROG_ARM` takes the next write as address and data. On a qualified write it moves to `ST_PROG_RUN`; otherwise it returns to `ST_IDLE` with flags set.
- `ST_ERASE_ARM` expects D0H. On a qualified confirm it moves to `ST_ERASE_RUN`; otherwise it returns to `ST_IDLE` with flags set.
- `ST_PROG_RUN` and `ST_ERASE_RUN` count their busy interval and then return to `ST_IDLE`.
- From either run state, a supply drop returns the machine to `ST_IDLE`.
- From any state, `hard_abort` returns the machine to `ST_IDLE`.

The array has 4 blocks of 16 bytes, addressed by `bus_addr[5:4]`. Block 0 is the boot block. A program ANDs the data into the byte: the low nibble is committed at busy cycle 4 and the high nibble at busy cycle 8. An erase writes FFH into one byte of the block every fourth busy cycle, in ascending order. Because of this, an interrupted operation leaves a partly written byte or block.

Top module: `flash_cmd_top`

## Requirements
- R1: After `rst_n` the array holds FFH everywhere, the read mode is array, and the status byte is 80H. Status layout: bit 7 = ready, bit 6 = 0 (no suspend), bit 5 = erase fault, bit 4 = program fault, bit 3 = supply-low, bits 2..0 = 0.
- R2: Writing 40H, then a write of (A, D), makes byte A equal to its old value AND D. Status bit 7 reads 0 for exactly 8 cycles, starting in the cycle after the data write.
- R3: A program can only clear bits. Programming a 1 over a stored 0 leaves the 0 and raises no fault.
- R4: Writing 20H, then D0H to any address in block B, sets all 16 bytes of block B to FFH after exactly 64 busy cycles. Other blocks are unchanged.
- R5: If the write after 20H is not D0H, bits 5 and 4 are both set and nothing is erased. That write is not decoded as a new command, and the machine returns to idle.
- R6: If `vpp_good` is 0 at the operand or confirm write, bit 3 and the fault bit of the operation (bit 4 for program, bit 5 for erase) are set. The array is unchanged and the block never goes busy.
- R7: A program or erase aimed at block 0 while `boot_unlock` is 0 sets the fault bit of that operation and leaves the array unchanged. With `boot_unlock` at 1 the operation proceeds.
- R8: Opcodes 40H, 20H and 70H select status reads. That mode persists through and after operations until FFH selects array reads. `bus_rdata` is 0 unless `bus_ce` and `bus_oe` are both 1.
- R9: If `vpp_good` falls during a busy interval, the machine is ready in the next cycle with bit 3 and the operation's fault bit set. Only the part of the write completed before the drop remains in the array.
- R10: `hard_abort` halts any operation, returns to ready and array-read mode, and clears bits 5..3. The array keeps what was written before the abort.
- R11: Bits 5, 4 and 3 are sticky across later successful operations. Only opcode 50H (or `hard_abort`/`rst_n`) clears them.
- R12: Bus writes during a busy interval are ignored. They change neither the operation nor the read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of sequencer, status and array |
| hard_abort | input | 1 | Active-high halt: aborts operations and clears status |
| vpp_good | input | 1 | Programming supply present |
| boot_unlock | input | 1 | Enables program/erase of block 0 |
| bus_ce | input | 1 | Chip enable |
| bus_we | input | 1 | Write enable; a write is taken at a clock edge with `bus_ce` |
| bus_oe | input | 1 | Output enable |
| bus_addr | input | 6 | Byte address; bits 5..4 select the block |
| bus_wdata | input | 8 | Command or operand byte |
| bus_rdata | output | 8 | Array byte or status byte (combinational) |

## Verification
The status byte and array reads are combinational from registered state. A write lands at one clock edge, and the bench samples 1 ns after the falling edge that follows it: that is the first cycle the new state is visible. Program busy is counted as 8 status reads with bit 7 low and erase busy as 64, starting at the first falling edge after the command's data edge. Rejected operations must show ready at that first read. The partial-write checks place the supply drop or abort in a known busy cycle, the 5th for a program and the 20th for an erase. The expected array contents come from the commit schedule: the nibble at busy cycles 4 and 8, and one erased byte every fourth cycle.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_ARM,
        ST_ERASE_ARM,
        ST_PROG_RUN,
        ST_ERASE_RUN
    } wsm_state_t;

    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STAT   = 8'h70;
    localparam logic [7:0] OP_CLR_STAT    = 8'h50;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [7:0]        pgm_val,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] ers_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            if (pgm_en) mem_q[pgm_addr] <= mem_q[pgm_addr] & pgm_val;
            if (ers_en) mem_q[ers_addr] <= 8'hFF;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R3: a program commit never turns a 0 into a 1
    a_r3_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_en && !ers_en) |=> ((mem_q[$past(pgm_addr)] & ~$past(mem_q[pgm_addr])) == 8'h00));

    // R4: an erase step leaves its byte at FFH
    a_r4_erase_ff: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> (mem_q[$past(ers_addr)] == 8'hFF));

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_abort,
    input  logic              vpp_good,
    input  logic              boot_unlock,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              stat_mode,
    output logic [7:0]        status_byte,
    output logic              pgm_en,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_val,
    output logic              ers_en,
    output logic [ADDR_W-1:0] ers_addr
);
    localparam int BYTE_W     = ADDR_W - BLK_W;
    localparam int BLK_BYTES  = 1 << BYTE_W;
    localparam int ERASE_STEP = ERASE_CYC / BLK_BYTES;
    localparam int MAX_CYC    = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC) + 1;
    localparam int PROG_HALF  = PROG_CYC / 2;

    wsm_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] tgt_addr_q, tgt_addr_d;
    logic [7:0]        tgt_data_q, tgt_data_d;
    logic              mode_q, mode_d;
    logic              e_err_q, e_err_d, p_err_q, p_err_d, v_low_q, v_low_d;
    logic              boot_hit, running;

    assign boot_hit = (wr_addr[ADDR_W-1 -: BLK_W] == '0);
    assign running  = (state_q == ST_PROG_RUN) || (state_q == ST_ERASE_RUN);

    // next-state and status update
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        tgt_addr_d = tgt_addr_q;
        tgt_data_d = tgt_data_q;
        mode_d     = mode_q;
        e_err_d    = e_err_q;
        p_err_d    = p_err_q;
        v_low_d    = v_low_q;
        if (hard_abort) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            mode_d  = 1'b0;
            e_err_d = 1'b0;
            p_err_d = 1'b0;
            v_low_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (wr_stb) begin
                    case (wr_data)
                        OP_READ_ARRAY:  mode_d = 1'b0;
                        OP_READ_STAT:   mode_d = 1'b1;
                        OP_CLR_STAT: begin
                            e_err_d = 1'b0;
                            p_err_d = 1'b0;
                            v_low_d = 1'b0;
                        end
                        OP_PROG_SETUP: begin
                            state_d = ST_PROG_ARM;
                            mode_d  = 1'b1;
                        end
                        OP_ERASE_SETUP: begin
                            state_d = ST_ERASE_ARM;
                            mode_d  = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_PROG_ARM: if (wr_stb) begin
                    state_d = ST_IDLE;
                    if (!vpp_good) begin
                        v_low_d = 1'b1;
                        p_err_d = 1'b1;
                    end else if (boot_hit && !boot_unlock) begin
                        p_err_d = 1'b1;
                    end else begin
                        state_d    = ST_PROG_RUN;
                        cnt_d      = '0;
                        tgt_addr_d = wr_addr;
                        tgt_data_d = wr_data;
                    end
                end
                ST_ERASE_ARM: if (wr_stb) begin
                    state_d = ST_IDLE;
                    if (wr_data != OP_ERASE_GO) begin
                        e_err_d = 1'b1;
                        p_err_d = 1'b1;
                    end else if (!vpp_good) begin
                        v_low_d = 1'b1;
                        e_err_d = 1'b1;
                    end else if (boot_hit && !boot_unlock) begin
                        e_err_d = 1'b1;
                    end else begin
                        state_d    = ST_ERASE_RUN;
                        cnt_d      = '0;
                        tgt_addr_d = wr_addr;
                    end
                end
                ST_PROG_RUN: begin
                    if (!vpp_good) begin
                        state_d = ST_IDLE;
                        v_low_d = 1'b1;
                        p_err_d = 1'b1;
                    end else if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_ERASE_RUN: begin
                    if (!vpp_good) begin
                        state_d = ST_IDLE;
                        v_low_d = 1'b1;
                        e_err_d = 1'b1;
                    end else if (cnt_q == CNT_W'(ERASE_CYC - 1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            tgt_addr_q <= '0;
            tgt_data_q <= 8'hFF;
            mode_q     <= 1'b0;
            e_err_q    <= 1'b0;
            p_err_q    <= 1'b0;
            v_low_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            tgt_addr_q <= tgt_addr_d;
            tgt_data_q <= tgt_data_d;
            mode_q     <= mode_d;
            e_err_q    <= e_err_d;
            p_err_q    <= p_err_d;
            v_low_q    <= v_low_d;
        end
    end

    // outputs
    always_comb begin
        pgm_en      = (state_q == ST_PROG_RUN) && vpp_good && !hard_abort &&
                      ((cnt_q == CNT_W'(PROG_HALF - 1)) || (cnt_q == CNT_W'(PROG_CYC - 1)));
        pgm_addr    = tgt_addr_q;
        pgm_val     = (cnt_q == CNT_W'(PROG_HALF - 1)) ? {4'hF, tgt_data_q[3:0]}
                                                       : {tgt_data_q[7:4], 4'hF};
        ers_en      = (state_q == ST_ERASE_RUN) && vpp_good && !hard_abort &&
                      ((cnt_q % CNT_W'(ERASE_STEP)) == CNT_W'(ERASE_STEP - 1));
        ers_addr    = {tgt_addr_q[ADDR_W-1 -: BLK_W], BYTE_W'(cnt_q / CNT_W'(ERASE_STEP))};
        stat_mode   = mode_q;
        status_byte = {!running, 1'b0, e_err_q, p_err_q, v_low_q, 3'b000};
    end

    // R5: bad confirm raises both fault flags
    a_r5_bad_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_ARM && wr_stb && wr_data != OP_ERASE_GO && !hard_abort)
        |=> (e_err_q && p_err_q && state_q == ST_IDLE));

    // R6: program operand with supply low is refused
    a_r6_vpp_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_ARM && wr_stb && !vpp_good && !hard_abort)
        |=> (v_low_q && p_err_q && state_q == ST_IDLE));

    // R9: supply loss while busy halts and flags
    a_r9_vpp_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !vpp_good && !hard_abort) |=> (state_q == ST_IDLE && v_low_q));

    // R10: abort returns to ready, array mode, clean status
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        hard_abort |=> (state_q == ST_IDLE && !mode_q && !e_err_q && !p_err_q && !v_low_q));

    // R11: fault flags never fall without clear or abort
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_abort && !(state_q == ST_IDLE && wr_stb && wr_data == OP_CLR_STAT))
        |=> (($past({e_err_q, p_err_q, v_low_q}) & ~{e_err_q, p_err_q, v_low_q}) == 3'b000));

    // R12: writes while busy leave target and mode alone
    a_r12_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_stb && !hard_abort)
        |=> ($stable(tgt_addr_q) && $stable(tgt_data_q) && $stable(mode_q)));

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_abort,
    input  logic              vpp_good,
    input  logic              boot_unlock,
    input  logic              bus_ce,
    input  logic              bus_we,
    input  logic              bus_oe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic              wr_stb, stat_mode, pgm_en, ers_en;
    logic [7:0]        status_byte, pgm_val, arr_rd;
    logic [ADDR_W-1:0] pgm_addr, ers_addr;

    assign wr_stb = bus_ce && bus_we;

    flash_wsm #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) wsm_i (
        .clk(clk), .rst_n(rst_n), .hard_abort(hard_abort), .vpp_good(vpp_good),
        .boot_unlock(boot_unlock), .wr_stb(wr_stb), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .stat_mode(stat_mode), .status_byte(status_byte),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_val(pgm_val),
        .ers_en(ers_en), .ers_addr(ers_addr)
    );

    flash_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst_n(rst_n),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_val(pgm_val),
        .ers_en(ers_en), .ers_addr(ers_addr),
        .rd_addr(bus_addr), .rd_data(arr_rd)
    );

    always_comb begin
        if (bus_ce && bus_oe) bus_rdata = stat_mode ? status_byte : arr_rd;
        else                  bus_rdata = 8'h00;
    end

endmodule

// File: tb/flash_cmd_top_tb.sv
module flash_cmd_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hard_abort = 1'b0;
    logic       vpp_good = 1'b1;
    logic       boot_unlock = 1'b0;
    logic       bus_ce = 1'b0, bus_we = 1'b0, bus_oe = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_top dut_i (
        .clk(clk), .rst_n(rst_n), .hard_abort(hard_abort), .vpp_good(vpp_good),
        .boot_unlock(boot_unlock), .bus_ce(bus_ce), .bus_we(bus_we), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic       is_erase;
        logic [5:0] addr;
        logic [7:0] data;
        logic       vpp;
        logic       boot;
        logic [7:0] exp_st;
        logic [5:0] chk_a;
        logic [7:0] exp_b;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'h12, 8'h5A, 1'b1, 1'b0, 8'h80, 6'h12, 8'h5A, 4'd2},
        '{1'b0, 6'h12, 8'hF0, 1'b1, 1'b0, 8'h80, 6'h12, 8'h50, 4'd2},
        '{1'b0, 6'h12, 8'hFF, 1'b1, 1'b0, 8'h80, 6'h12, 8'h50, 4'd3},
        '{1'b0, 6'h13, 8'h00, 1'b0, 1'b0, 8'h98, 6'h13, 8'hFF, 4'd6},
        '{1'b0, 6'h03, 8'h00, 1'b1, 1'b0, 8'h90, 6'h03, 8'hFF, 4'd7},
        '{1'b0, 6'h03, 8'h3C, 1'b1, 1'b1, 8'h80, 6'h03, 8'h3C, 4'd7},
        '{1'b1, 6'h1E, 8'h00, 1'b1, 1'b0, 8'h80, 6'h12, 8'hFF, 4'd4},
        '{1'b1, 6'h05, 8'h00, 1'b1, 1'b0, 8'hA0, 6'h03, 8'h3C, 4'd7},
        '{1'b1, 6'h2A, 8'h00, 1'b0, 1'b0, 8'hA8, 6'h2A, 8'hFF, 4'd6},
        '{1'b1, 6'h07, 8'h00, 1'b1, 1'b1, 8'h80, 6'h03, 8'hFF, 4'd7},
        '{1'b0, 6'h35, 8'h81, 1'b1, 1'b0, 8'h80, 6'h35, 8'h81, 4'd2},
        '{1'b1, 6'h30, 8'h00, 1'b1, 1'b0, 8'h80, 6'h35, 8'hFF, 4'd4},
        '{1'b0, 6'h2F, 8'h00, 1'b1, 1'b0, 8'h80, 6'h2F, 8'h00, 4'd2},
        '{1'b1, 6'h31, 8'h00, 1'b1, 1'b0, 8'h80, 6'h2F, 8'h00, 4'd4}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_ce = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_ce = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_ce = 1'b1; bus_oe = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_ce = 1'b0; bus_oe = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        logic [7:0] s;
        n = 0;
        forever begin
            br(6'h00, s);
            if (s[7]) break;
            n++;
            if (n > 500) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        int nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, array mode, erased array
        br(6'h21, r);           check("R1 array after reset", r, 8'hFF);
        bw(6'h00, 8'h70);
        br(6'h00, r);           check("R1 status after reset", r, 8'h80);
        // R8: idle bus reads 0
        @(negedge clk); bus_ce = 1'b1; bus_oe = 1'b0; #1;
        check("R8 rdata without oe", bus_rdata, 8'h00);
        bus_ce = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            bw(6'h00, 8'h50);
            vpp_good = v.vpp; boot_unlock = v.boot;
            if (v.is_erase) begin bw(v.addr, 8'h20); bw(v.addr, 8'hD0); end
            else            begin bw(v.addr, 8'h40); bw(v.addr, v.data); end
            wait_ready(nb);
            br(v.addr, r);
            check({tag_name(v.tag), " status"}, r, v.exp_st);
            check({tag_name(v.tag), " busy cycles"}, nb,
                  (v.exp_st == 8'h80) ? (v.is_erase ? 64 : 8) : 0);
            vpp_good = 1'b1; boot_unlock = 1'b0;
            bw(6'h00, 8'hFF);
            br(v.chk_a, r);
            check({tag_name(v.tag), " array byte"}, r, v.exp_b);
        end

        // R5: bad confirm, second write not decoded as a command
        bw(6'h00, 8'h50);
        bw(6'h20, 8'h20);
        bw(6'h20, 8'h40);
        br(6'h20, r);           check("R5 both faults", r, 8'hB0);
        bw(6'h00, 8'hFF);
        br(6'h2F, r);           check("R5 no erase, idle", r, 8'h00);

        // R11: faults survive a successful program
        bw(6'h14, 8'h40);
        bw(6'h14, 8'h00);
        wait_ready(nb);
        br(6'h14, r);           check("R11 sticky after success", r, 8'hB0);
        bw(6'h00, 8'h50);
        br(6'h00, r);           check("R11 cleared by 50H", r, 8'h80);
        br(6'h3F, r);           check("R8 status mode persists", r, 8'h80);

        // R12: writes during erase are ignored
        bw(6'h10, 8'h20);
        bw(6'h10, 8'hD0);
        bw(6'h00, 8'hFF);
        bw(6'h00, 8'h40);
        wait_ready(nb);
        br(6'h14, r);           check("R12 mode unchanged by busy writes", r, 8'h80);
        bw(6'h00, 8'hFF);
        br(6'h14, r);           check("R12 erase completed", r, 8'hFF);

        // R9: supply drop in 5th busy cycle of a program
        bw(6'h25, 8'h40);
        bw(6'h25, 8'h00);
        repeat (5) @(negedge clk);
        vpp_good = 1'b0;
        br(6'h00, r);           check("R9 ready with faults", r, 8'h98);
        vpp_good = 1'b1;
        bw(6'h00, 8'hFF);
        br(6'h25, r);           check("R9 partial program", r, 8'hF0);

        // R10: abort in 20th busy cycle of an erase
        bw(6'h30, 8'h40); bw(6'h30, 8'h00); wait_ready(nb);
        bw(6'h34, 8'h40); bw(6'h34, 8'h00); wait_ready(nb);
        bw(6'h33, 8'h20);
        bw(6'h33, 8'hD0);
        repeat (20) @(negedge clk);
        hard_abort = 1'b1;
        @(negedge clk);
        hard_abort = 1'b0;
        br(6'h30, r);           check("R10 array mode, byte 0 erased", r, 8'hFF);
        br(6'h34, r);           check("R10 byte 4 untouched", r, 8'h00);
        bw(6'h00, 8'h70);
        br(6'h00, r);           check("R10 status cleared", r, 8'h80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule